// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM with a two-stage pipeline. It accepts a read, a write or a deselect on every clock-enabled edge. Writes are delayed through the same pipeline as reads, so reads and writes can alternate on consecutive cycles with no idle cycle between them. A command is either a load, which carries a fresh address, chip selects and direction, or an advance. An advance continues the last loaded operation at the next address of a four-beat wrapping burst. The burst runs in linear or interleaved order.

The data bus is split into a write-data input, a read-data output and an output-drive flag; a pad wrapper turns these into bidirectional pins. An output-enable input and a sleep input remove the drive at once, without waiting for a clock. While asleep the block ignores every other input and keeps its array contents. For a parameterised number of clocks after waking, the block refuses write loads and raises an error flag for each one.

Top module: `pipe_sram`

## Requirements
- R1: A read load issued with the chip selected makes `rdata_o` hold the addressed word, and `drive_o` go high, right after the second clock-enabled edge that follows the command edge. Both hold until the next clock-enabled edge.
- R2: A write load captures `wdata_i` at the second clock-enabled edge after the command. Byte b (bits `[8b+7:8b]`) is written only if `byte_wen_ni[b]` was low at the command edge. Other bytes keep their value.
- R3: Read and write commands may alternate on consecutive edges. A read issued one edge after a write to the same address returns the bytes that the write enabled, merged with the old contents of the other bytes.
- R4: An edge with `clk_en_ni` high changes no state. The pipeline, the output word and the burst position are all frozen.
- R5: The chip is selected on a load only when `sel0_ni`=0, `sel1_i`=1 and `sel2_ni`=0. A deselected load neither writes nor drives the bus.
- R6: On an advance (`adv_i`=1) the select, direction and address inputs are ignored. The last loaded operation repeats at the next beat. With `burst_lin_i`=1, beat k uses address bits [1:0] = start+k mod 4. With `burst_lin_i`=0, beat k uses start XOR k. The upper address bits stay fixed, and the beats wrap after four.
- R7: `drive_o` is low in the same cycle that `oe_ni` is high, with no clock edge needed.
- R8: While `sleep_i` is high, `drive_o` is low and all other inputs are ignored. Pending commands are discarded, a following advance is a deselect, and array contents are kept.
- R9: For WAKE_CYC clocks after `sleep_i` falls, a selected write load is dropped and `wr_err_o` is high for the one clock after that edge. Reads are served normally in this window.
- R10: After reset, `drive_o` and `wr_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high masks the edge |
| sel0_ni | input | 1 | Chip select, active low, sampled on load |
| sel1_i | input | 1 | Chip select, active high, sampled on load |
| sel2_ni | input | 1 | Chip select, active low, sampled on load |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| rd_i | input | 1 | On load: 1 = read, 0 = write |
| addr_i | input | ADDR_W | Word address, sampled on load |
| byte_wen_ni | input | NBYTE | Byte write enables, active low |
| burst_lin_i | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous low-power request |
| wdata_i | input | NBYTE*BYTE_W | Write data |
| rdata_o | output | NBYTE*BYTE_W | Read data |
| drive_o | output | 1 | Read data is to be driven onto the pins |
| wr_err_o | output | 1 | Write issued in the wake recovery window |

## Verification
A read result is due right after the second clock-enabled edge that follows its command. Write data is taken at that same second edge. The error flag follows one clock after the offending edge. A drive removal caused by `oe_ni` or `sleep_i` shows in the same cycle. The bench advances its reference model on the rising edge, counting only clock-enabled edges as pipeline steps. It compares `drive_o`, `wr_err_o` and, while driven, `rdata_o` at every falling edge. Inputs change just after the rising edge, so each sample lands between edges.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // beat k of a 4-beat wrap burst from start
  function automatic logic [1:0] beat_low(input logic [1:0] start, input logic [1:0] k,
                                          input logic lin);
    return lin ? (start + k) : (start ^ k);
  endfunction
endpackage

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 2,
  parameter int BYTE_W = 8,
  localparam int DATA_W = NBYTE * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [NBYTE-1:0]  wbe_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[b]) mem_q[wa_i][b*BYTE_W +: BYTE_W] <= wd_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/pipe_sram_burst.sv
module pipe_sram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  import pipe_sram_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;

  assign beat_nx = beat_q + 2'd1;
  assign addr_o  = load_i ? addr_i
                          : {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_nx, lin_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_nx;
    end
  end
endmodule

// File: rtl/pipe_sram_wake.sv
module pipe_sram_wake #(
  parameter int WAKE_CYC = 4,
  localparam int CW = $clog2(WAKE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (sleep_i)       cnt_q <= CW'(WAKE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int ADDR_W   = 6,
  parameter int NBYTE    = 2,
  parameter int BYTE_W   = 8,
  parameter int WAKE_CYC = 4,
  localparam int DATA_W  = NBYTE * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              sel0_ni,
  input  logic              sel1_i,
  input  logic              sel2_ni,
  input  logic              adv_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBYTE-1:0]  byte_wen_ni,
  input  logic              burst_lin_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o,
  output logic              wr_err_o
);
  import pipe_sram_pkg::*;

  logic acc, load, step, chip_on, wake_busy, bad_wr;
  op_e  cmd_op, burst_op_q;
  logic [ADDR_W-1:0] cmd_addr;

  op_e               s1_op_q, s2_op_q;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic [NBYTE-1:0]  s1_be_q, s2_be_q;
  logic [DATA_W-1:0] s2_data_q, arr_rd, fwd_rd, out_q;
  logic              out_vld_q, err_q;

  assign acc     = !clk_en_ni && !sleep_i;
  assign load    = acc && !adv_i;
  assign step    = acc && adv_i;
  assign chip_on = !sel0_ni && sel1_i && !sel2_ni;
  assign bad_wr  = load && chip_on && !rd_i && wake_busy;

  always_comb begin
    if (load) begin
      if (!chip_on || bad_wr) cmd_op = OP_NONE;
      else                    cmd_op = rd_i ? OP_READ : OP_WRITE;
    end else begin
      cmd_op = burst_op_q;
    end
  end

  pipe_sram_burst #(.ADDR_W(ADDR_W)) i_burst (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .lin_i(burst_lin_i),
    .addr_i, .addr_o(cmd_addr)
  );

  pipe_sram_wake #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk_i, .rst_ni, .sleep_i, .busy_o(wake_busy)
  );

  pipe_sram_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) i_array (
    .clk_i,
    .we_i (acc && s2_op_q == OP_WRITE),
    .wa_i (s2_addr_q),
    .wbe_i(s2_be_q),
    .wd_i (wdata_i),
    .ra_i (s1_addr_q),
    .rd_o (arr_rd)
  );

  // a write retiring on this edge is not yet in the array
  for (genvar b = 0; b < NBYTE; b++) begin : g_fwd
    assign fwd_rd[b*BYTE_W +: BYTE_W] =
      (s2_op_q == OP_WRITE && s2_addr_q == s1_addr_q && s2_be_q[b])
        ? wdata_i[b*BYTE_W +: BYTE_W] : arr_rd[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_op_q <= OP_NONE;
      s1_op_q    <= OP_NONE;
      s2_op_q    <= OP_NONE;
      s1_addr_q  <= '0;
      s2_addr_q  <= '0;
      s1_be_q    <= '0;
      s2_be_q    <= '0;
      s2_data_q  <= '0;
      out_q      <= '0;
      out_vld_q  <= 1'b0;
    end else if (sleep_i) begin
      burst_op_q <= OP_NONE;
      s1_op_q    <= OP_NONE;
      s2_op_q    <= OP_NONE;
      out_vld_q  <= 1'b0;
    end else if (acc) begin
      if (load) burst_op_q <= cmd_op;
      s1_op_q   <= cmd_op;
      s1_addr_q <= cmd_addr;
      s1_be_q   <= ~byte_wen_ni;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
      if (s1_op_q == OP_READ) s2_data_q <= fwd_rd;
      out_vld_q <= (s2_op_q == OP_READ);
      if (s2_op_q == OP_READ) out_q <= s2_data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= bad_wr;
  end

  assign rdata_o  = out_q;
  assign drive_o  = out_vld_q && !oe_ni && !sleep_i;
  assign wr_err_o = err_q;
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_ni,
  input logic sel0_ni,
  input logic sel1_i,
  input logic sel2_ni,
  input logic adv_i,
  input logic rd_i,
  input logic oe_ni,
  input logic sleep_i,
  input logic [15:0] rdata_o,
  input logic drive_o,
  input logic wr_err_o
);
  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || sleep_i) |-> !drive_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_ni && !sleep_i) |=> $stable(rdata_o));

  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(!clk_en_ni && !sleep_i && !adv_i && !rd_i));

  assert_sleep_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !wr_err_o);

  assert_desel_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !adv_i && !(!sel0_ni && sel1_i && !sel2_ni)) |=> !wr_err_o);
endmodule

bind pipe_sram pipe_sram_chk i_chk (
  .clk_i, .rst_ni, .clk_en_ni, .sel0_ni, .sel1_i, .sel2_ni, .adv_i, .rd_i,
  .oe_ni, .sleep_i, .rdata_o(rdata_o[15:0]), .drive_o, .wr_err_o
);

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clk_en_ni = 1'b1, sel0_ni = 1'b0, sel1_i = 1'b1, sel2_ni = 1'b0;
  logic adv_i = 1'b0, rd_i = 1'b1, burst_lin_i = 1'b1, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [1:0]  byte_wen_ni = '1;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        drive_o, wr_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_sram #(.ADDR_W(6), .NBYTE(2), .BYTE_W(8), .WAKE_CYC(WAKE)) i_pipe_sram (
    .clk_i(clk), .rst_ni, .clk_en_ni, .sel0_ni, .sel1_i, .sel2_ni, .adv_i, .rd_i,
    .addr_i, .byte_wen_ni, .burst_lin_i, .oe_ni, .sleep_i, .wdata_i,
    .rdata_o, .drive_o, .wr_err_o
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R10";
  logic done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  // ---------------- reference model ----------------
  typedef struct { int op; int addr; logic [1:0] bw; } cmd_t;  // op 0 none,1 rd,2 wr
  cmd_t        q[$];
  logic [15:0] m_mem [64];
  int          m_bop = 0, m_k = 0, m_wake = 0;
  logic [5:0]  m_base = '0;
  logic        m_vld = 1'b0, m_err = 1'b0;
  logic [15:0] m_out = '0;

  task automatic flush_q();
    cmd_t z;
    z.op = 0; z.addr = 0; z.bw = 2'b11;
    q.delete(); q.push_back(z); q.push_back(z);
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q(); m_bop = 0; m_k = 0; m_base = '0; m_wake = 0;
      m_vld = 1'b0; m_err = 1'b0; m_out = '0;
    end else if (sleep_i) begin
      flush_q(); m_bop = 0; m_vld = 1'b0; m_err = 1'b0; m_wake = WAKE;
    end else begin
      logic e_n;
      e_n = 1'b0;
      if (!clk_en_ni) begin
        cmd_t c, h;
        if (!adv_i) begin
          if (!sel0_ni && sel1_i && !sel2_ni) c.op = rd_i ? 1 : 2;
          else c.op = 0;
          if (c.op == 2 && m_wake > 0) begin c.op = 0; e_n = 1'b1; end
          m_bop = c.op; m_base = addr_i; m_k = 0; c.addr = int'(addr_i);
        end else begin
          logic [1:0] lo;
          m_k = (m_k + 1) % 4;
          lo = burst_lin_i ? 2'(m_base[1:0] + 2'(m_k)) : (m_base[1:0] ^ 2'(m_k));
          c.addr = int'({m_base[5:2], lo}); c.op = m_bop;
        end
        c.bw = byte_wen_ni;
        h = q.pop_front();
        if (h.op == 2) begin
          if (!h.bw[0]) m_mem[h.addr][7:0]  = wdata_i[7:0];
          if (!h.bw[1]) m_mem[h.addr][15:8] = wdata_i[15:8];
        end
        m_vld = (h.op == 1);
        if (h.op == 1) m_out = m_mem[h.addr];
        q.push_back(c);
      end
      m_err = e_n;
      if (m_wake > 0) m_wake--;
    end
  end

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic exp_drv;
    exp_drv = m_vld && !oe_ni && !sleep_i;
    check("drive_o", 16'(drive_o), 16'(exp_drv));
    check("wr_err_o", 16'(wr_err_o), 16'(m_err));
    if (exp_drv && drive_o) check("rdata_o", rdata_o, m_out);
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    wdata_i = lfsr[15:0];
  endtask

  task automatic sel_on();
    sel0_ni = 1'b0; sel1_i = 1'b1; sel2_ni = 1'b0;
  endtask

  task automatic rd_c(input logic [5:0] a);
    clk_en_ni = 1'b0; adv_i = 1'b0; rd_i = 1'b1; addr_i = a; byte_wen_ni = 2'b00; sel_on(); tick();
  endtask

  task automatic wr_c(input logic [5:0] a, input logic [1:0] bw);
    clk_en_ni = 1'b0; adv_i = 1'b0; rd_i = 1'b0; addr_i = a; byte_wen_ni = bw; sel_on(); tick();
  endtask

  task automatic adv_c(input logic [1:0] bw);
    clk_en_ni = 1'b0; adv_i = 1'b1; rd_i = ~rd_i; addr_i = ~addr_i; byte_wen_ni = bw;
    sel0_ni = 1'b1; sel1_i = 1'b0; tick();
  endtask

  task automatic dsel_c(input int which);
    clk_en_ni = 1'b0; adv_i = 1'b0; rd_i = which[0]; addr_i = 6'd5; byte_wen_ni = 2'b00; sel_on();
    if (which == 0) sel0_ni = 1'b1;
    else if (which == 1) sel1_i = 1'b0;
    else sel2_ni = 1'b1;
    tick();
  endtask

  task automatic hold_c();
    clk_en_ni = 1'b1; adv_i = 1'b0; rd_i = 1'b0; addr_i = 6'd9; byte_wen_ni = 2'b00; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R10";
    check("reset drive_o", 16'(drive_o), 16'h0);
    check("reset wr_err_o", 16'(wr_err_o), 16'h0);
    rst_ni = 1'b1;
    tick();

    cur_req = "R2";  // full-word preload, back to back
    for (int i = 0; i < 64; i++) wr_c(6'(i), 2'b00);
    dsel_c(0); dsel_c(0);
    cur_req = "R1";
    for (int i = 0; i < 12; i++) rd_c(6'(i * 5));
    dsel_c(1); rd_c(6'd3); dsel_c(2); dsel_c(2); dsel_c(2);

    cur_req = "R2";  // partial bytes
    wr_c(6'd7, 2'b10); wr_c(6'd8, 2'b01); wr_c(6'd9, 2'b11);
    dsel_c(0); dsel_c(0); rd_c(6'd7); rd_c(6'd8); rd_c(6'd9); dsel_c(0); dsel_c(0);

    cur_req = "R3";  // alternate, same address, forwarding
    for (int i = 0; i < 8; i++) begin
      wr_c(6'd12, i[0] ? 2'b01 : 2'b00); rd_c(6'd12);
    end
    wr_c(6'd13, 2'b10); rd_c(6'd13); rd_c(6'd12); wr_c(6'd12, 2'b00); dsel_c(1); dsel_c(1);

    cur_req = "R4";  // clock enable gaps mid-pipeline
    rd_c(6'd20); hold_c(); hold_c(); wr_c(6'd21, 2'b00); hold_c(); rd_c(6'd21);
    hold_c(); dsel_c(0); hold_c(); hold_c(); dsel_c(0); rd_c(6'd21); dsel_c(0); hold_c(); dsel_c(0);

    cur_req = "R5";
    for (int w = 0; w < 3; w++) begin
      dsel_c(w); dsel_c(w);
      clk_en_ni = 1'b0; adv_i = 1'b0; rd_i = 1'b0; addr_i = 6'd30; byte_wen_ni = 2'b00; sel_on();
      if (w == 0) sel0_ni = 1'b1; else if (w == 1) sel1_i = 1'b0; else sel2_ni = 1'b1;
      tick();
    end
    dsel_c(0); dsel_c(0); rd_c(6'd30); rd_c(6'd5); dsel_c(0); dsel_c(0);

    cur_req = "R6";
    for (int m = 0; m < 2; m++) begin
      burst_lin_i = m[0];
      for (int s = 0; s < 4; s++) begin
        wr_c(6'(40 + s), 2'b00); adv_c(2'b00); adv_c(s[0] ? 2'b01 : 2'b00); adv_c(2'b00); adv_c(2'b00);
        rd_c(6'(40 + s)); adv_c(2'b00); adv_c(2'b00); adv_c(2'b00); adv_c(2'b00);
        dsel_c(0); adv_c(2'b00); dsel_c(0);
      end
    end
    burst_lin_i = 1'b1;

    cur_req = "R7";
    rd_c(6'd40); rd_c(6'd41); rd_c(6'd42);
    @(posedge clk); #3; oe_ni = 1'b1; #1;  // mid-cycle, before the falling edge
    rd_c(6'd43); oe_ni = 1'b0; dsel_c(0); oe_ni = 1'b1; dsel_c(0); oe_ni = 1'b0; dsel_c(0);

    cur_req = "R8";
    wr_c(6'd50, 2'b00); rd_c(6'd51); sleep_i = 1'b1; rd_c(6'd50);
    wr_c(6'd51, 2'b00); adv_c(2'b00); dsel_c(0);
    sleep_i = 1'b0;
    cur_req = "R9";
    wr_c(6'd50, 2'b00); rd_c(6'd50); adv_c(2'b00); rd_c(6'd51);
    for (int i = 0; i < WAKE; i++) dsel_c(0);
    wr_c(6'd50, 2'b00); dsel_c(0); dsel_c(0); rd_c(6'd50); dsel_c(0); dsel_c(0); dsel_c(0);
    cur_req = "R8";
    sleep_i = 1'b1; hold_c(); dsel_c(0); sleep_i = 1'b0; hold_c();
    for (int i = 0; i < WAKE; i++) rd_c(6'(i));
    dsel_c(0); dsel_c(0); dsel_c(0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule